// File: doc/BRIEF.md
# Per-Channel Zero-Data Detector

This block watches the decoded sample stream of a six-channel audio path and reports which channels have gone silent. Every time the sample strobe is high, each channel's 24-bit signed sample is compared with zero. The comparison uses only the bits that belong to the selected word length. Each channel keeps its own run counter. Once a channel has seen a long enough unbroken run of zero samples, its status flag turns active. A seventh flag turns active only when all six channels are silent together.

The flags feed external logic, such as muting relays or power management. For that reason one control bit chooses whether all seven outputs are active-high or active-low. Detection always looks at the data each channel actually received. Any copying of one channel's data onto others happens downstream and has no effect on the flags.

Top module: `zero_run_detector`

## Requirements
- R1: A channel's flag turns active after RUN_LEN (default 1024) consecutive strobed samples that compare as zero. It is not active after RUN_LEN-1 such samples.
- R2: Flag bit i belongs to sample lane i, and each flag depends only on its own lane. The order is bit 0 left 1, bit 1 right 1, bit 2 left 2, bit 3 right 2, bit 4 left 3, bit 5 right 3.
- R3: The global flag is active only while all six channel flags are active.
- R4: A strobed nonzero sample on a channel restarts that channel's run. Its flag is inactive from the clock edge that takes the sample onward, and a fresh full run is needed before it turns active again.
- R5: The run count saturates. A flag stays active through any number of further zero samples and never wraps back to inactive.
- R6: Polarity bit `pol_low_i` = 0 makes all seven flags active-high, and 1 makes them active-low. The bit acts on the outputs at once, without a clock.
- R7: Samples are MSB-aligned in 24 bits. Word length code 00 compares all 24 bits, 01 compares bits [23:4] (20-bit words), and 10 compares bits [23:8] (16-bit words). Code 11 is handled like 00.
- R8: Reset clears every run counter, and every flag then shows its inactive level for the current polarity.
- R9: Clock cycles without the strobe neither advance nor restart any run, whatever the sample inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample strobe, one per sample period |
| smp_data_i | input | NUM_CH x SAMPLE_W | Per-lane signed samples, lane i = flag bit i |
| pol_low_i | input | 1 | 0 = active-high flags, 1 = active-low flags |
| wlen_i | input | 2 | Word length code (00 = 24, 01 = 20, 10 = 16, 11 = 24) |
| chan_flag_o | output | NUM_CH | Per-channel zero-run flags |
| all_flag_o | output | 1 | All channels silent |

## Verification
Each flag is driven from one register per channel. A strobe taken at a rising edge is therefore visible right after that edge. The polarity bit reaches the outputs with no clock delay. The bench changes inputs on the falling edge and keeps the strobe high across exactly the number of rising edges each scenario needs. It reads the flags at the next falling edge, which is the first half-cycle in which the result is due. Threshold checks sit at RUN_LEN-1 and RUN_LEN strobes to pin down the cycle in which a flag turns active.

// File: rtl/zrd_pkg.sv
package zrd_pkg;

    typedef enum logic [1:0] {
        WLEN_24   = 2'b00,
        WLEN_20   = 2'b01,
        WLEN_16   = 2'b10,
        WLEN_RSVD = 2'b11
    } wlen_e;

    // Number of low-order bits outside the active word (samples are MSB aligned).
    function automatic int unsigned dropped_lsbs(wlen_e w);
        case (w)
            WLEN_20: return 4;
            WLEN_16: return 8;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/zrd_zero_cmp.sv
module zrd_zero_cmp
    import zrd_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 24
) (
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic [1:0]          wlen_i,
    output logic                zero_o
);

    logic [SAMPLE_W-1:0] keep;
    int unsigned         drop;

    always_comb begin
        drop = dropped_lsbs(wlen_e'(wlen_i));
        for (int i = 0; i < SAMPLE_W; i++) begin
            keep[i] = (i >= drop);
        end
        zero_o = ((sample_i & keep) == '0);
    end

endmodule

// File: rtl/zrd_run_counter.sv
module zrd_run_counter #(
    parameter int unsigned RUN_LEN = 1024
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic strobe_i,
    input  logic zero_i,
    output logic idle_o
);

    localparam int unsigned CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(RUN_LEN);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             idle;
    } run_state_t;

    run_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (strobe_i) begin
            if (!zero_i) begin
                st_d.cnt = '0;
            end else if (st_q.cnt != CNT_TOP) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            st_d.idle = (st_d.cnt == CNT_TOP);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idle_o = st_q.idle;

    AST_CLEAR_ON_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (strobe_i && !zero_i) |=> (!idle_o && st_q.cnt == '0)); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= CNT_TOP); // R5
    AST_STAY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (idle_o && strobe_i && zero_i) |=> idle_o); // R5
    AST_IDLE_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        idle_o |-> (st_q.cnt == CNT_TOP)); // R1
    AST_HOLD_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !strobe_i |=> ($stable(st_q.cnt) && $stable(idle_o))); // R9
    AST_RESET_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (st_q.cnt == '0 && !idle_o)); // R8

endmodule

// File: rtl/zero_run_detector.sv
module zero_run_detector #(
    parameter int unsigned NUM_CH   = 6,
    parameter int unsigned SAMPLE_W = 24,
    parameter int unsigned RUN_LEN  = 1024
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic                             smp_valid_i,
    input  logic [NUM_CH-1:0][SAMPLE_W-1:0]  smp_data_i,
    input  logic                             pol_low_i,
    input  logic [1:0]                       wlen_i,
    output logic [NUM_CH-1:0]                chan_flag_o,
    output logic                             all_flag_o
);

    logic [NUM_CH-1:0] lane_zero;
    logic [NUM_CH-1:0] lane_idle;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
        zrd_zero_cmp #(
            .SAMPLE_W (SAMPLE_W)
        ) u_cmp (
            .sample_i (smp_data_i[c]),
            .wlen_i   (wlen_i),
            .zero_o   (lane_zero[c])
        );

        zrd_run_counter #(
            .RUN_LEN (RUN_LEN)
        ) u_run (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .strobe_i (smp_valid_i),
            .zero_i   (lane_zero[c]),
            .idle_o   (lane_idle[c])
        );
    end

    always_comb begin
        chan_flag_o = lane_idle ^ {NUM_CH{pol_low_i}};
        all_flag_o  = (&lane_idle) ^ pol_low_i;
    end

    AST_GLOBAL_NEEDS_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (all_flag_o == !pol_low_i) |-> (chan_flag_o == {NUM_CH{!pol_low_i}})); // R3
    AST_GLOBAL_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (chan_flag_o != {NUM_CH{!pol_low_i}}) |-> (all_flag_o == pol_low_i)); // R3

endmodule

// File: tb/zero_run_detector_test.sv
module zero_run_detector_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam int RUN        = 1024;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              strobe = 1'b0;
    logic [5:0][23:0]  data = '0;
    logic              pol = 1'b0;
    logic [1:0]        wlen = 2'b00;
    logic [5:0]        flags;
    logic              all_f;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    zero_run_detector uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .smp_valid_i (strobe),
        .smp_data_i  (data),
        .pol_low_i   (pol),
        .wlen_i      (wlen),
        .chan_flag_o (flags),
        .all_flag_o  (all_f)
    );

    task automatic check(string tag, logic [5:0] exp_f, logic exp_a);
        checks++;
        if (flags !== exp_f || all_f !== exp_a) begin
            errors++;
            $display("FAIL %s: flags=%h all=%b expected flags=%h all=%b",
                     tag, flags, all_f, exp_f, exp_a);
        end
    endtask

    task automatic do_reset();
        strobe = 1'b0;
        rst_n  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Keeps the strobe high across exactly n rising edges; returns on a falling edge.
    task automatic push(int n);
        repeat (n) begin
            @(negedge clk);
            strobe = 1'b1;
        end
        @(negedge clk);
        strobe = 1'b0;
    endtask

    task automatic t_reset();
        pol = 1'b0;
        do_reset();
        check("R8 reset active-high", 6'h00, 1'b0);
        pol = 1'b1;
        #1;
        check("R8 R6 reset active-low", 6'h3F, 1'b1);
        pol = 1'b0;
        #1;
    endtask

    task automatic t_threshold();
        data = '0;
        wlen = 2'b00;
        push(RUN - 1);
        check("R1 one short of run", 6'h00, 1'b0);
        push(1);
        check("R1 R3 run reached", 6'h3F, 1'b1);
    endtask

    task automatic t_saturate();
        push(3000);
        check("R5 long silence", 6'h3F, 1'b1);
    endtask

    task automatic t_clear();
        data[2] = 24'h000001;
        push(1);
        check("R4 nonzero clears lane 2", 6'h3B, 1'b0);
        data[2] = '0;
        push(1);
        check("R4 run restarts", 6'h3B, 1'b0);
    endtask

    task automatic t_polarity();
        pol = 1'b1;
        #1;
        check("R6 active-low view", 6'h04, 1'b1);
        pol = 1'b0;
        #1;
        check("R6 back to active-high", 6'h3B, 1'b0);
    endtask

    task automatic t_hold();
        do_reset();
        data = '0;
        push(RUN - 1);
        for (int c = 0; c < 6; c++) data[c] = 24'h800000;
        repeat (200) @(negedge clk);
        check("R9 idle cycles ignore data", 6'h00, 1'b0);
        data = '0;
        push(1);
        check("R9 run continued", 6'h3F, 1'b1);
    endtask

    task automatic t_wlen();
        wlen = 2'b01;
        do_reset();
        for (int c = 0; c < 6; c++) data[c] = 24'h00000F;
        push(RUN);
        check("R7 20-bit ignores low nibble", 6'h3F, 1'b1);
        data[0] = 24'h000010;
        push(1);
        check("R7 20-bit bit4 counts", 6'h3E, 1'b0);

        wlen = 2'b10;
        do_reset();
        for (int c = 0; c < 6; c++) data[c] = 24'h0000FF;
        push(RUN);
        check("R7 16-bit ignores low byte", 6'h3F, 1'b1);
        data[5] = 24'h000100;
        push(1);
        check("R7 16-bit bit8 counts", 6'h1F, 1'b0);

        wlen = 2'b00;
        do_reset();
        for (int c = 0; c < 6; c++) data[c] = 24'h000001;
        push(RUN);
        check("R7 24-bit uses LSB", 6'h00, 1'b0);

        wlen = 2'b11;
        push(RUN);
        check("R7 code 11 as 24-bit", 6'h00, 1'b0);
        wlen = 2'b00;
    endtask

    task automatic t_order();
        for (int k = 0; k < 6; k++) begin
            do_reset();
            data = '0;
            data[k] = 24'h400000;
            push(RUN);
            check($sformatf("R2 lane %0d busy", k), 6'h3F & ~(6'h01 << k), 1'b0);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_threshold();
        t_saturate();
        t_clear();
        t_polarity();
        t_hold();
        t_wlen();
        t_order();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule